// File: doc/BRIEF.md
# Operand Address Generator with Index Redirection

This block forms the 14-bit effective operand address for a small 8-bit accumulator CPU. The decoder hands it an opcode byte with a strobe, a two-bit addressing-mode select and a three-bit operation class. Operand bytes that follow the opcode arrive one per strobe. A short-form address comes from the five low opcode bits. A direct-page address comes from the one operand byte. A long jump target comes from two operand bytes. An indexed address is the current value of the index register. The finished address is shown for one cycle with a valid flag. An addressing mode that the operation class may not use raises a one-cycle error flag and produces no address.

The block also owns a 256-byte direct-page store with its own combinational-read, clocked-write port. The index register lives inside this store at `$0F`. The location at `$0E` is a window: any read or write to it reaches the byte whose address is the index value. The window works for one level only. When the index itself holds `$0E`, a read through the window returns zero and a write through it is dropped.

The sequencer has four states:
- `ST_IDLE` waits for an opcode.
- `ST_DIR_WAIT` waits for the direct operand.
- `ST_EXT_HI` waits for the upper jump byte.
- `ST_EXT_LO` waits for the lower jump byte.

Its transitions are:
- An opcode strobe in any state restarts decoding. It goes to `ST_DIR_WAIT` for direct mode, to `ST_EXT_HI` for a legal extended request, and otherwise to `ST_IDLE`, where it emits the address or raises the error.
- From `ST_DIR_WAIT`, an operand strobe returns to `ST_IDLE` and emits.
- From `ST_EXT_HI`, an operand strobe captures the upper bits and moves to `ST_EXT_LO`.
- From `ST_EXT_LO`, an operand strobe returns to `ST_IDLE` and emits.
- With no strobe, every state holds.

Top module: `oag_top`

## Requirements
- R1: After reset the valid and error flags are low, and reading `$0F` returns `$00`.
- R2: Mode 0 (short) with class 0 (clear), 1 (load) or 2 (store): one cycle after the opcode strobe, the valid flag is high and the address is opcode bits 4:0 zero-extended to 14 bits.
- R3: Mode 0 with any class other than 0, 1 or 2 raises the error flag one cycle after the opcode strobe, and the valid flag stays low.
- R4: Mode 1 (direct): the valid flag stays low until the operand strobe. One cycle after that strobe, the address is the operand byte zero-extended to 14 bits.
- R5: Mode 2 (extended) with class 3 (jump) or 4 (subroutine jump): the first operand byte supplies address bits 13:8, with its top two bits ignored. The second operand byte supplies bits 7:0. The valid flag rises one cycle after the second strobe.
- R6: Mode 2 with any class other than 3 or 4 raises the error flag one cycle after the opcode strobe, with no valid output.
- R7: Mode 3 (indexed): one cycle after the opcode strobe, the address is the index register value sampled at that strobe, zero-extended.
- R8: The index register is at direct-page address `$0F` and is read and written through the memory port like any other location.
- R9: A read or write at port address `$0E` reaches the location whose address equals the index register value.
- R10: When the index register holds `$0E`, a read at `$0E` returns `$00` and a write at `$0E` changes nothing.
- R11: An opcode strobe while an address is pending discards the pending capture and starts over. An operand strobe with nothing pending is ignored.
- R12: The error and valid flags are never high together, and each error lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| opc_stb_i | input | 1 | Opcode byte strobe |
| opc_i | input | 8 | Opcode byte |
| mode_i | input | 2 | Addressing mode: 0 short, 1 direct, 2 extended, 3 indexed |
| cls_i | input | 3 | Operation class: 0 clear, 1 load, 2 store, 3 jump, 4 subroutine jump, 5-7 other |
| opnd_stb_i | input | 1 | Operand byte strobe |
| opnd_i | input | 8 | Operand byte |
| addr_o | output | 14 | Effective operand address |
| addr_vld_o | output | 1 | Address valid, one cycle |
| mode_err_o | output | 1 | Illegal mode/class combination, one cycle |
| dp_addr_i | input | 8 | Direct-page port address |
| dp_we_i | input | 1 | Direct-page write enable |
| dp_wdata_i | input | 8 | Direct-page write data |
| dp_rdata_o | output | 8 | Direct-page read data, combinational |

## Verification
Several rules are checked by assertions on every cycle:
- the timing and value of short-mode addresses;
- the error response to illegal short and extended requests;
- the mutual exclusion of the two flags;
- the index register taking the value written to `$0F`;
- the zero read through a self-pointing window.

Other behaviour needs ordered stimulus, so only the bench scenarios show it:
- the two-byte assembly of extended addresses, including the masked top bits;
- the restart when an opcode arrives mid-capture;
- an operand strobe being ignored when nothing is pending;
- a window write landing at the indexed location and leaving it untouched when it is blocked.

// File: rtl/oag_pkg.sv
package oag_pkg;

    typedef enum logic [1:0] {
        MD_SHORT  = 2'd0,
        MD_DIRECT = 2'd1,
        MD_EXT    = 2'd2,
        MD_INDEX  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        CL_CLEAR = 3'd0,
        CL_LOAD  = 3'd1,
        CL_STORE = 3'd2,
        CL_JUMP  = 3'd3,
        CL_CALL  = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIR_WAIT,
        ST_EXT_HI,
        ST_EXT_LO
    } state_e;

endpackage

// File: rtl/oag_legal.sv
module oag_legal (
    input  logic [2:0] cls_i,
    output logic       short_ok_o,
    output logic       ext_ok_o
);
    import oag_pkg::*;

    always_comb begin
        short_ok_o = (cls_i == CL_CLEAR) || (cls_i == CL_LOAD) || (cls_i == CL_STORE);
        ext_ok_o   = (cls_i == CL_JUMP) || (cls_i == CL_CALL);
    end
endmodule

// File: rtl/oag_seq.sv
module oag_seq #(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_stb_i,
    input  logic [DATA_W-1:0] opc_i,
    input  logic [1:0]        mode_i,
    input  logic              short_ok_i,
    input  logic              ext_ok_i,
    input  logic              opnd_stb_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] xval_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vld_o,
    output logic              err_o
);
    import oag_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    state_e            state_q, state_d;
    logic [HI_W-1:0]   hi_q;
    logic              emit, raise_err, cap_hi;
    logic [ADDR_W-1:0] emit_addr;

    always_comb begin
        state_d   = state_q;
        emit      = 1'b0;
        raise_err = 1'b0;
        cap_hi    = 1'b0;
        emit_addr = '0;
        if (opc_stb_i) begin
            unique case (mode_e'(mode_i))
                MD_SHORT: begin
                    state_d = ST_IDLE;
                    if (short_ok_i) begin
                        emit      = 1'b1;
                        emit_addr = {{(ADDR_W-SHORT_W){1'b0}}, opc_i[SHORT_W-1:0]};
                    end else begin
                        raise_err = 1'b1;
                    end
                end
                MD_DIRECT: state_d = ST_DIR_WAIT;
                MD_EXT: begin
                    if (ext_ok_i) begin
                        state_d = ST_EXT_HI;
                    end else begin
                        state_d   = ST_IDLE;
                        raise_err = 1'b1;
                    end
                end
                MD_INDEX: begin
                    state_d   = ST_IDLE;
                    emit      = 1'b1;
                    emit_addr = {{(ADDR_W-DATA_W){1'b0}}, xval_i};
                end
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_DIR_WAIT: if (opnd_stb_i) begin
                    state_d   = ST_IDLE;
                    emit      = 1'b1;
                    emit_addr = {{(ADDR_W-DATA_W){1'b0}}, opnd_i};
                end
                ST_EXT_HI: if (opnd_stb_i) begin
                    state_d = ST_EXT_LO;
                    cap_hi  = 1'b1;
                end
                ST_EXT_LO: if (opnd_stb_i) begin
                    state_d   = ST_IDLE;
                    emit      = 1'b1;
                    emit_addr = {hi_q, opnd_i};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            err_o  <= 1'b0;
            addr_o <= '0;
            hi_q   <= '0;
        end else begin
            vld_o <= emit;
            err_o <= raise_err;
            if (emit)   addr_o <= emit_addr;
            if (cap_hi) hi_q   <= opnd_i[HI_W-1:0];
        end
    end
endmodule

// File: rtl/oag_dpmem.sv
module oag_dpmem #(
    parameter int DP_AW     = 8,
    parameter int DATA_W    = 8,
    parameter int IDX_ADDR  = 15,
    parameter int WIN_ADDR  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DP_AW-1:0]  addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] x_o
);
    localparam int DEPTH = 1 << DP_AW;
    localparam logic [DP_AW-1:0] IDX = DP_AW'(IDX_ADDR);
    localparam logic [DP_AW-1:0] WIN = DP_AW'(WIN_ADDR);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DP_AW-1:0]  tgt;
    logic              blocked;

    assign x_o = mem[IDX];

    always_comb begin
        tgt     = (addr_i == WIN) ? mem[IDX][DP_AW-1:0] : addr_i;
        blocked = (tgt == WIN);
        rdata_o = blocked ? '0 : mem[tgt];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i && !blocked) begin
            mem[tgt] <= wdata_i;
        end
    end
endmodule

// File: rtl/oag_top.sv
module oag_top #(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_stb_i,
    input  logic [DATA_W-1:0] opc_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        cls_i,
    input  logic              opnd_stb_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              mode_err_o,
    input  logic [DATA_W-1:0] dp_addr_i,
    input  logic              dp_we_i,
    input  logic [DATA_W-1:0] dp_wdata_i,
    output logic [DATA_W-1:0] dp_rdata_o
);
    logic              short_ok, ext_ok;
    logic [DATA_W-1:0] x_val;

    oag_legal u_legal (
        .cls_i      (cls_i),
        .short_ok_o (short_ok),
        .ext_ok_o   (ext_ok)
    );

    oag_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .opc_stb_i  (opc_stb_i),
        .opc_i      (opc_i),
        .mode_i     (mode_i),
        .short_ok_i (short_ok),
        .ext_ok_i   (ext_ok),
        .opnd_stb_i (opnd_stb_i),
        .opnd_i     (opnd_i),
        .xval_i     (x_val),
        .addr_o     (addr_o),
        .vld_o      (addr_vld_o),
        .err_o      (mode_err_o)
    );

    oag_dpmem #(.DP_AW(DATA_W), .DATA_W(DATA_W), .IDX_ADDR(15), .WIN_ADDR(14)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (dp_addr_i),
        .we_i    (dp_we_i),
        .wdata_i (dp_wdata_i),
        .rdata_o (dp_rdata_o),
        .x_o     (x_val)
    );
endmodule

// File: rtl/oag_chk.sv
module oag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        opc_stb_i,
    input logic [7:0]  opc_i,
    input logic [1:0]  mode_i,
    input logic [2:0]  cls_i,
    input logic [13:0] addr_o,
    input logic        addr_vld_o,
    input logic        mode_err_o,
    input logic [7:0]  dp_addr_i,
    input logic        dp_we_i,
    input logic [7:0]  dp_wdata_i,
    input logic [7:0]  dp_rdata_o,
    input logic [7:0]  x_val
);
    assert_short_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_stb_i && mode_i == 2'd0 && cls_i <= 3'd2)
        |=> (addr_vld_o && addr_o == {9'b0, $past(opc_i[4:0])}));

    assert_short_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_stb_i && mode_i == 2'd0 && cls_i > 3'd2) |=> (mode_err_o && !addr_vld_o));

    assert_ext_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_stb_i && mode_i == 2'd2 && cls_i != 3'd3 && cls_i != 3'd4)
        |=> (mode_err_o && !addr_vld_o));

    assert_index_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_we_i && dp_addr_i == 8'h0F) |=> (x_val == $past(dp_wdata_i)));

    assert_self_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_addr_i == 8'h0E && x_val == 8'h0E) |-> (dp_rdata_o == 8'h00));

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_err_o && addr_vld_o));

    assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err_o && !opc_stb_i) |=> !mode_err_o);
endmodule

bind oag_top oag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opc_stb_i  (opc_stb_i),
    .opc_i      (opc_i),
    .mode_i     (mode_i),
    .cls_i      (cls_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o),
    .mode_err_o (mode_err_o),
    .dp_addr_i  (dp_addr_i),
    .dp_we_i    (dp_we_i),
    .dp_wdata_i (dp_wdata_i),
    .dp_rdata_o (dp_rdata_o),
    .x_val      (x_val)
);

// File: tb/tb_oag_top.sv
`timescale 1ns/1ps
module tb_oag_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        opc_stb_i, opnd_stb_i, dp_we_i;
    logic [7:0]  opc_i, opnd_i, dp_addr_i, dp_wdata_i, dp_rdata_o;
    logic [1:0]  mode_i;
    logic [2:0]  cls_i;
    logic [13:0] addr_o;
    logic        addr_vld_o, mode_err_o;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    oag_top dut (
        .clk(clk), .rst_n(rst_n), .opc_stb_i(opc_stb_i), .opc_i(opc_i),
        .mode_i(mode_i), .cls_i(cls_i), .opnd_stb_i(opnd_stb_i), .opnd_i(opnd_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o), .mode_err_o(mode_err_o),
        .dp_addr_i(dp_addr_i), .dp_we_i(dp_we_i), .dp_wdata_i(dp_wdata_i),
        .dp_rdata_o(dp_rdata_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic opcode(input logic [1:0] m, input logic [2:0] c, input logic [7:0] o);
        @(negedge clk);
        opc_stb_i = 1'b1; mode_i = m; cls_i = c; opc_i = o;
        @(negedge clk);
        opc_stb_i = 1'b0;
    endtask

    task automatic operand(input logic [7:0] b);
        @(negedge clk);
        opnd_stb_i = 1'b1; opnd_i = b;
        @(negedge clk);
        opnd_stb_i = 1'b0;
    endtask

    task automatic dp_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dp_we_i = 1'b1; dp_addr_i = a; dp_wdata_i = d;
        @(negedge clk);
        dp_we_i = 1'b0;
    endtask

    task automatic dp_read_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        dp_addr_i = a;
        #1;
        chk(dp_rdata_o == exp, req, dp_rdata_o, exp);
    endtask

    task automatic t_reset;
        chk(!addr_vld_o, "R1 valid", addr_vld_o, 0);
        chk(!mode_err_o, "R1 error", mode_err_o, 0);
        dp_read_chk(8'h0F, 8'h00, "R1 index");
    endtask

    task automatic t_short;
        opcode(2'd0, 3'd0, 8'h00);
        chk(addr_vld_o && addr_o == 14'h0000, "R2 low", addr_o, 14'h0000);
        opcode(2'd0, 3'd1, 8'hFF);
        chk(addr_vld_o && addr_o == 14'h001F, "R2 high", addr_o, 14'h001F);
        opcode(2'd0, 3'd2, 8'h2E);
        chk(addr_vld_o && addr_o == 14'h000E, "R2 store", addr_o, 14'h000E);
        @(negedge clk);
        chk(!addr_vld_o, "R2 one-cycle", addr_vld_o, 0);
    endtask

    task automatic t_short_bad;
        opcode(2'd0, 3'd3, 8'h05);
        chk(mode_err_o && !addr_vld_o, "R3 jump", mode_err_o, 1);
        opcode(2'd0, 3'd6, 8'h05);
        chk(mode_err_o && !addr_vld_o, "R3 other", mode_err_o, 1);
        @(negedge clk);
        chk(!mode_err_o, "R12 err pulse", mode_err_o, 0);
    endtask

    task automatic t_direct;
        opcode(2'd1, 3'd1, 8'h00);
        chk(!addr_vld_o, "R4 wait", addr_vld_o, 0);
        operand(8'hFF);
        chk(addr_vld_o && addr_o == 14'h00FF, "R4 top", addr_o, 14'h00FF);
        opcode(2'd1, 3'd5, 8'h00);
        operand(8'h00);
        chk(addr_vld_o && addr_o == 14'h0000, "R4 zero", addr_o, 14'h0000);
    endtask

    task automatic t_ext;
        opcode(2'd2, 3'd3, 8'h00);
        operand(8'hFF);
        chk(!addr_vld_o, "R5 mid", addr_vld_o, 0);
        operand(8'hFF);
        chk(addr_vld_o && addr_o == 14'h3FFF, "R5 max", addr_o, 14'h3FFF);
        opcode(2'd2, 3'd4, 8'h00);
        operand(8'hC0);
        operand(8'h00);
        chk(addr_vld_o && addr_o == 14'h0000, "R5 masked", addr_o, 14'h0000);
        opcode(2'd2, 3'd4, 8'h00);
        operand(8'h12);
        operand(8'h34);
        chk(addr_vld_o && addr_o == 14'h1234, "R5 mixed", addr_o, 14'h1234);
    endtask

    task automatic t_ext_bad;
        opcode(2'd2, 3'd1, 8'h00);
        chk(mode_err_o && !addr_vld_o, "R6 load", mode_err_o, 1);
        operand(8'h01);
        chk(!addr_vld_o, "R6 no capture", addr_vld_o, 0);
    endtask

    task automatic t_window;
        dp_write(8'h0F, 8'h40);
        dp_read_chk(8'h0F, 8'h40, "R8 readback");
        dp_write(8'h0E, 8'hA5);
        dp_read_chk(8'h40, 8'hA5, "R9 write lands");
        dp_read_chk(8'h0E, 8'hA5, "R9 read through");
        opcode(2'd3, 3'd1, 8'h00);
        chk(addr_vld_o && addr_o == 14'h0040, "R7 indexed", addr_o, 14'h0040);
        dp_write(8'h0F, 8'h0E);
        dp_write(8'h0E, 8'h77);
        dp_read_chk(8'h0E, 8'h00, "R10 self read");
        dp_read_chk(8'h0F, 8'h0E, "R10 index kept");
        dp_write(8'h0F, 8'h40);
        dp_read_chk(8'h40, 8'hA5, "R10 target kept");
    endtask

    task automatic t_restart;
        opcode(2'd2, 3'd3, 8'h00);
        operand(8'h11);
        opcode(2'd0, 3'd1, 8'h05);
        chk(addr_vld_o && addr_o == 14'h0005, "R11 restart", addr_o, 14'h0005);
        operand(8'h22);
        chk(!addr_vld_o, "R11 stray operand", addr_vld_o, 0);
        chk(addr_o == 14'h0005, "R11 addr held", addr_o, 14'h0005);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; opc_stb_i = 0; opnd_stb_i = 0; dp_we_i = 0;
        opc_i = 0; opnd_i = 0; mode_i = 0; cls_i = 0; dp_addr_i = 0; dp_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short();
        t_short_bad();
        t_direct();
        t_ext();
        t_ext_bad();
        t_window();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule